// File: doc/BRIEF.md
# Indexed RTC Periodic Interrupt Unit

This block is the periodic-interrupt part of a real-time-clock peripheral. Software reaches it through two byte addresses. A write to the index address picks an internal register. The next read or write at the data address then reaches that register. The top bit of every index write is kept as a separate NMI-mask output and is not part of the register selector.

Three registers are held. The rate register combines a four-bit periodic rate code with a three-bit divider-control field. The control register holds the periodic interrupt enable. The flag register reports pending events and clears itself on read. A free-running prescaler counts pulses of a 32.768 kHz reference tick and sets the periodic flag at the chosen rate. The interrupt line stays high until software reads the flag register.

Top module: `rtc_pi_unit`

## Requirements
- R1: After reset, `irq` and `nmi_block` are 0, and the rate register (selector 0x0A), the control register (selector 0x0B) and the flag register (selector 0x0C) all read 0x00.
- R2: A write at the index address (`bus_addr`=0) loads `nmi_block` from bit 7 of the written byte. Bits 6:0 form the selector, so index bytes 0x8A and 0x0A both select the rate register.
- R3: A rate code r from 1 to 15 (rate register bits 3:0) sets the periodic flag once every 2^(r-1) reference ticks, counted from the moment the divider starts running. Code 6 gives 1024 Hz. Code 0 never sets the flag.
- R4: The divider field (rate register bits 6:4) must be 3'b010 for the prescaler to count. Any other value holds the prescaler at zero, so no periodic event occurs.
- R5: A read of the flag register returns the pending flags, with the periodic flag in bit 6. It clears every flag that it returned as set. An event that arrives in the same cycle as the read is kept and shows up in the next read.
- R6: Once `irq` has risen, it stays high, however many further events arrive, until the flag register is read. It is low in the cycle after that read, provided no event arrives in the read cycle.
- R7: Flag bit 7 and `irq` are both equal to (periodic flag AND control register bit 6). With the enable clear, events set only bit 6. Setting the enable while a flag is pending raises `irq`.
- R8: Writes to the flag register are ignored. The rate register reads back bit 7 as 0. The control register reads back all eight bits as written. Selectors other than 0x0A, 0x0B and 0x0C read 0x00, and a read at the index address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle pulse at 32.768 kHz |
| bus_addr | input | 1 | 0 selects the index address, 1 selects the data address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the same cycle as `bus_rd` |
| irq | output | 1 | Periodic interrupt request |
| nmi_block | output | 1 | NMI-mask bit latched from the last index write |

## Verification
The bench sweeps every rate code from 1 to 15. For each code it first parks the divider and then starts it, so the expected period is exactly 2^(r-1) ticks. It reads the flags one tick before the event and then on the event itself, which tells a correct period apart from one that is off by a tick or off by a power of two. Rate code 0 and a divider value other than 3'b010 are both run for many ticks and must leave the flags clear. This separates gating by the rate code from gating by the divider. Further read patterns separate the cases of clear-on-read, an event landing in the read cycle, a held interrupt, and an enable applied after an event is already pending.

// File: rtl/rtc_pi_pkg.sv
package rtc_pi_pkg;
   localparam logic [6:0] SEL_RATE = 7'h0A;
   localparam logic [6:0] SEL_CTRL = 7'h0B;
   localparam logic [6:0] SEL_FLAG = 7'h0C;
   localparam logic [2:0] DIV_RUN  = 3'b010;
   localparam int         PIE_BIT  = 6;
   localparam int         PF_BIT   = 6;
   localparam int         IRQF_BIT = 7;
endpackage

// File: rtl/rtc_pi_index.sv
module rtc_pi_index #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              idx_wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-2:0] sel,
   output logic              nmi_block
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel       <= '0;
         nmi_block <= 1'b0;
      end else if (idx_wr) begin
         sel       <= wdata[DATA_W-2:0];
         nmi_block <= wdata[DATA_W-1];
      end
   end
endmodule

// File: rtl/rtc_pi_prescale.sv
module rtc_pi_prescale #(
   parameter int RATE_W = 4,
   parameter int CNT_W  = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_tick,
   input  logic              run,
   input  logic [RATE_W-1:0] rate,
   output logic              ev
);
   localparam int NCODES = 1 << RATE_W;

   logic [CNT_W-1:0]  cnt;
   logic [NCODES-1:0] hit;

   initial begin
      assert (CNT_W >= NCODES - 2) else $error("prescaler too narrow for rate field");
   end

   // One tap per rate code: code k fires when the low k-1 count bits are all ones.
   generate
      for (genvar k = 0; k < NCODES; k++) begin : g_tap
         if (k == 0) begin : g_off
            assign hit[k] = 1'b0;
         end else if (k == 1) begin : g_every
            assign hit[k] = 1'b1;
         end else begin : g_pow
            assign hit[k] = &cnt[k-2:0];
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || !run) cnt <= '0;
      else if (ref_tick)  cnt <= cnt + 1'b1;
   end

   assign ev = run & ref_tick & hit[rate];
endmodule

// File: rtl/rtc_pi_flags.sv
module rtc_pi_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic ev,
   input  logic rd_clear,
   input  logic pie,
   output logic pf,
   output logic irq
);
   always_ff @(posedge clk) begin
      if (!rst_n) pf <= 1'b0;
      else        pf <= (pf & ~rd_clear) | ev;
   end

   assign irq = pf & pie;
endmodule

// File: rtl/rtc_pi_unit.sv
module rtc_pi_unit
   import rtc_pi_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int RATE_W = 4,
   parameter int CNT_W  = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_tick,
   input  logic              bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq,
   output logic              nmi_block
);
   localparam int SEL_W = DATA_W - 1;

   initial begin
      assert (DATA_W == 8) else $error("register file is byte wide");
      assert (RATE_W >= 1 && RATE_W <= 4) else $error("rate field must fit below divider");
   end

   logic [SEL_W-1:0]  sel;
   logic [DATA_W-2:0] reg_rate;
   logic [DATA_W-1:0] reg_ctrl;
   logic              ev, pf, run, rd_clear, data_wr, data_rd;

   assign data_wr  = bus_wr & bus_addr;
   assign data_rd  = bus_rd & bus_addr;
   assign rd_clear = data_rd && (sel == SEL_FLAG);
   assign run      = (reg_rate[6:4] == DIV_RUN);

   rtc_pi_index #(.DATA_W(DATA_W)) u_index (
      .clk(clk), .rst_n(rst_n), .idx_wr(bus_wr & ~bus_addr),
      .wdata(bus_wdata), .sel(sel), .nmi_block(nmi_block)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reg_rate <= '0;
         reg_ctrl <= '0;
      end else if (data_wr) begin
         if (sel == SEL_RATE) reg_rate <= bus_wdata[DATA_W-2:0];
         if (sel == SEL_CTRL) reg_ctrl <= bus_wdata;
      end
   end

   rtc_pi_prescale #(.RATE_W(RATE_W), .CNT_W(CNT_W)) u_prescale (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .run(run),
      .rate(reg_rate[RATE_W-1:0]), .ev(ev)
   );

   rtc_pi_flags u_flags (
      .clk(clk), .rst_n(rst_n), .ev(ev), .rd_clear(rd_clear),
      .pie(reg_ctrl[PIE_BIT]), .pf(pf), .irq(irq)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_addr) begin
         unique case (sel)
            SEL_RATE: bus_rdata = {1'b0, reg_rate};
            SEL_CTRL: bus_rdata = reg_ctrl;
            SEL_FLAG: begin
               bus_rdata[PF_BIT]   = pf;
               bus_rdata[IRQF_BIT] = irq;
            end
            default:  bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/rtc_pi_unit_chk.sv
module rtc_pi_unit_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       bus_addr,
   input logic       bus_wr,
   input logic       bus_rd,
   input logic [7:0] bus_wdata,
   input logic [6:0] sel,
   input logic [6:0] reg_rate,
   input logic [7:0] reg_ctrl,
   input logic       ev,
   input logic       pf,
   input logic       irq,
   input logic       nmi_block
);
   logic rd_flag, wr_ctrl;
   assign rd_flag = bus_rd & bus_addr & (sel == 7'h0C);
   assign wr_ctrl = bus_wr & bus_addr & (sel == 7'h0B);

   // R2
   p_nmi_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !bus_addr) |=> (nmi_block == $past(bus_wdata[7])));

   // R4
   p_div_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rate[6:4] != 3'b010) |-> !ev);

   // R5
   p_clear_on_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_flag && !ev) |=> !pf);

   // R5: an event in the read cycle survives the read
   p_event_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ev |=> pf);

   // R6
   p_irq_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !rd_flag && !wr_ctrl) |=> irq);

   // R7
   p_irq_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (reg_ctrl[6] && pf));
endmodule

bind rtc_pi_unit rtc_pi_unit_chk u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
   .bus_rd(bus_rd), .bus_wdata(bus_wdata), .sel(sel), .reg_rate(reg_rate),
   .reg_ctrl(reg_ctrl), .ev(ev), .pf(pf), .irq(irq), .nmi_block(nmi_block)
);

// File: tb/rtc_pi_unit_bench.sv
module rtc_pi_unit_bench;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG_CYCLES = 190000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_tick = 1'b0;
   logic       bus_addr = 1'b0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       irq, nmi_block;

   int  n_tests = 0;
   int  n_fail = 0;
   bit  done = 1'b0;
   logic [7:0] rv;

   always #(CLK_PERIOD/2) clk = ~clk;

   rtc_pi_unit u_rtc_pi_unit (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq(irq), .nmi_block(nmi_block)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic wr_idx(input logic [7:0] v);
      @(negedge clk);
      bus_addr = 1'b0; bus_wr = 1'b1; bus_wdata = v;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic wr_data(input logic [7:0] v);
      @(negedge clk);
      bus_addr = 1'b1; bus_wr = 1'b1; bus_wdata = v;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_data(input bit with_tick, output logic [7:0] v);
      @(negedge clk);
      bus_addr = 1'b1; bus_rd = 1'b1; ref_tick = with_tick;
      #1 v = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0; ref_tick = 1'b0;
   endtask

   task automatic rd_idx(output logic [7:0] v);
      @(negedge clk);
      bus_addr = 1'b0; bus_rd = 1'b1;
      #1 v = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); ref_tick = 1'b1;
         @(negedge clk); ref_tick = 1'b0;
      end
   endtask

   task automatic read_reg(input logic [7:0] idx, output logic [7:0] v);
      wr_idx(idx);
      rd_data(1'b0, v);
   endtask

   task automatic write_reg(input logic [7:0] idx, input logic [7:0] v);
      wr_idx(idx);
      wr_data(v);
   endtask

   // Park the divider, drop pending flags, then start with the given rate byte.
   task automatic restart(input logic [7:0] rate_byte);
      logic [7:0] d;
      write_reg(8'h0A, 8'h00);
      read_reg(8'h0C, d);
      write_reg(8'h0A, rate_byte);
      wr_idx(8'h0C);
   endtask

   initial begin
      repeat (WATCHDOG_CYCLES) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual 00 expected 01");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      check("R1 irq", {7'd0, irq}, 8'h00);
      check("R1 nmi", {7'd0, nmi_block}, 8'h00);
      read_reg(8'h0A, rv); check("R1 rate reg", rv, 8'h00);
      read_reg(8'h0B, rv); check("R1 ctrl reg", rv, 8'h00);
      read_reg(8'h0C, rv); check("R1 flag reg", rv, 8'h00);

      // R2 NMI mask bit from index writes
      write_reg(8'h8A, 8'h15);
      check("R2 nmi set", {7'd0, nmi_block}, 8'h01);
      read_reg(8'h0A, rv); check("R2 selector ignores bit7", rv, 8'h15);
      check("R2 nmi cleared", {7'd0, nmi_block}, 8'h00);

      // R8 readback rules and ignored accesses
      write_reg(8'h0A, 8'hFF);
      read_reg(8'h0A, rv); check("R8 rate bit7 reads 0", rv, 8'h7F);
      write_reg(8'h0B, 8'hA5);
      read_reg(8'h0B, rv); check("R8 ctrl readback", rv, 8'hA5);
      write_reg(8'h0B, 8'h00);
      write_reg(8'h0C, 8'hFF);
      read_reg(8'h0C, rv); check("R8 flag write ignored", rv, 8'h00);
      read_reg(8'h0D, rv); check("R8 unknown selector", rv, 8'h00);
      rd_idx(rv); check("R8 index read", rv, 8'h00);

      // R3 sweep of every rate code
      for (int r = 1; r <= 15; r++) begin
         restart(8'h20 | 8'(r));
         ticks((1 << (r - 1)) - 1);
         rd_data(1'b0, rv); check($sformatf("R3 rate %0d before", r), rv, 8'h00);
         ticks(1);
         rd_data(1'b0, rv); check($sformatf("R3 rate %0d at period", r), rv, 8'h40);
         rd_data(1'b0, rv); check($sformatf("R3 rate %0d cleared", r), rv, 8'h00);
      end
      // R3 1024 Hz: code 6 repeats every 32 ticks
      restart(8'h26);
      ticks(32);
      rd_data(1'b0, rv); check("R3 1024Hz first", rv, 8'h40);
      ticks(31);
      rd_data(1'b0, rv); check("R3 1024Hz early", rv, 8'h00);
      ticks(1);
      rd_data(1'b0, rv); check("R3 1024Hz second", rv, 8'h40);
      // R3 code 0 disables
      restart(8'h20);
      ticks(300);
      rd_data(1'b0, rv); check("R3 code 0 silent", rv, 8'h00);

      // R4 divider gating
      restart(8'h36);
      ticks(200);
      rd_data(1'b0, rv); check("R4 divider 011 held", rv, 8'h00);
      restart(8'h06);
      ticks(200);
      rd_data(1'b0, rv); check("R4 divider 000 held", rv, 8'h00);

      // R5 event in the read cycle is held
      restart(8'h21);
      ticks(1);
      rd_data(1'b1, rv); check("R5 read returns prior flag", rv, 8'h40);
      rd_data(1'b0, rv); check("R5 simultaneous event held", rv, 8'h40);
      rd_data(1'b0, rv); check("R5 cleared after read", rv, 8'h00);

      // R7 enable gating
      restart(8'h23);
      ticks(4);
      check("R7 no irq without enable", {7'd0, irq}, 8'h00);
      write_reg(8'h0B, 8'h40);
      check("R7 enable raises irq on pending", {7'd0, irq}, 8'h01);

      // R6 irq held until flag read
      wr_idx(8'h0C);
      ticks(12);
      check("R6 irq held", {7'd0, irq}, 8'h01);
      rd_data(1'b0, rv); check("R7 flag bit7 set", rv, 8'hC0);
      check("R6 irq drops after read", {7'd0, irq}, 8'h00);
      ticks(4);
      check("R6 irq again on next event", {7'd0, irq}, 8'h01);
      write_reg(8'h0B, 8'h00);
      check("R7 disable drops irq", {7'd0, irq}, 8'h00);
      read_reg(8'h0C, rv); check("R7 bit7 off when disabled", rv, 8'h40);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule